// File: doc/BRIEF.md
# 32-bit Instruction Field Decoder

This block splits one aligned 32-bit instruction word into its fields and rebuilds its immediate in the same cycle. It has no state: every output depends only on the word at the input. The register specifiers, the function fields and the opcode are taken from fixed bit positions. The format class comes from the opcode. The immediate is put back together from the pieces that the format scatters across the word, and it is sign-extended from instruction bit 31.

A fetch or decode stage places the block after the instruction register. The block also marks two kinds of word. One kind is a word whose two lowest bits show a length other than 32 bits. The other is a word whose opcode is outside the supported set. A later stage can then raise an exception without decoding the word again.

Top module: `instr_field_dec`

## Requirements
- R1: `opcode_o`=inst[6:0], `rd_o`=inst[11:7], `funct3_o`=inst[14:12], `rs1_o`=inst[19:15], `rs2_o`=inst[24:20] and `funct7_o`=inst[31:25] for every word, whatever its format.
- R2: The register-immediate class (opcodes 0010011, 0000011, 1100111) yields `imm_o` = inst[31:20] sign-extended, giving a range of -2048 to 2047.
- R3: The store class (opcode 0100011) yields `imm_o` = {inst[31:25], inst[11:7]} sign-extended, giving a range of -2048 to 2047.
- R4: The branch class (opcode 1100011) yields `imm_o` = {inst[31], inst[7], inst[30:25], inst[11:8], 0} sign-extended, an even value from -4096 to 4094.
- R5: The upper class (opcodes 0110111, 0010111) yields `imm_o` = {inst[31:12], 12'h000}.
- R6: The jump class (opcode 1101111) yields `imm_o` = {inst[31], inst[19:12], inst[20], inst[30:21], 0} sign-extended, an even value from -1048576 to 1048574.
- R7: `fmt_o` encodes the class as 0=register-register (opcode 0110011), 1=register-immediate, 2=store, 3=branch, 4=upper, 5=jump and 7=unsupported. `illegal_o` is 1 exactly when `fmt_o` is 7, that is, for any opcode not named in R2 to R7.
- R8: `not32_o` is 1 exactly when inst[1:0] is not 2'b11. Every such word is also unsupported, so `illegal_o` is 1 and `imm_o` is 0.
- R9: `imm_o` is 0 for the register-register class and for unsupported words.
- R10: For every class that carries an immediate, the top bit of `imm_o` equals inst[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word |
| opcode_o | output | 7 | Major opcode |
| rd_o | output | 5 | Destination register specifier |
| rs1_o | output | 5 | First source register specifier |
| rs2_o | output | 5 | Second source register specifier |
| funct3_o | output | 3 | Minor function field |
| funct7_o | output | 7 | Upper function field |
| fmt_o | output | 3 | Format class code (R7) |
| imm_o | output | XLEN | Sign-extended immediate |
| illegal_o | output | 1 | Opcode not supported |
| not32_o | output | 1 | Length bits show a non-32-bit word |

## Verification
The length check and the format classification both read the low opcode bits, so a single word can trip both flags together. The bench provokes this by clearing bit 0 or bit 1 of every supported opcode while the upper bits are random. For each such word it expects `not32_o` and `illegal_o` to rise together, with `fmt_o` at 7 and `imm_o` at zero, rather than a valid class. The immediate extremes are provoked with hand-built words that set all payload bits with the sign clear, and that clear all payload bits with the sign set. A behavioural reference that adds weighted bit pieces judges the result for each class.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  localparam int unsigned ILEN = 32;
  localparam int unsigned OPC_W = 7;
  localparam int unsigned REG_W = 5;
  localparam int unsigned F3_W = 3;
  localparam int unsigned F7_W = 7;
  localparam int unsigned FMT_W = 3;

  localparam logic [OPC_W-1:0] OPC_ALU_REG  = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_ALU_IMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD     = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_JUMP_REG = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE    = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH   = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_UPPER    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_PC_UPPER = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JUMP     = 7'b1101111;

  typedef enum logic [FMT_W-1:0] {
    FMT_REG  = 3'd0,
    FMT_IMM  = 3'd1,
    FMT_STO  = 3'd2,
    FMT_BRA  = 3'd3,
    FMT_UPP  = 3'd4,
    FMT_JMP  = 3'd5,
    FMT_NONE = 3'd7
  } fmt_e;

  typedef struct packed {
    logic [F7_W-1:0]  funct7;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rs1;
    logic [F3_W-1:0]  funct3;
    logic [REG_W-1:0] rd;
    logic [OPC_W-1:0] opcode;
  } fields_t;

endpackage

// File: rtl/instr_dec_fields.sv
module instr_dec_fields
  import instr_dec_pkg::*;
(
  input  logic [ILEN-1:0] inst_i,
  output fields_t         fields_o
);

  // the struct layout matches the word bit for bit
  always_comb begin
    fields_o.opcode = inst_i[6:0];
    fields_o.rd     = inst_i[11:7];
    fields_o.funct3 = inst_i[14:12];
    fields_o.rs1    = inst_i[19:15];
    fields_o.rs2    = inst_i[24:20];
    fields_o.funct7 = inst_i[31:25];
  end

endmodule

// File: rtl/instr_dec_class.sv
module instr_dec_class
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output fmt_e             fmt_o,
  output logic             illegal_o,
  output logic             not32_o
);

  always_comb begin
    unique case (opcode_i)
      OPC_ALU_REG:                       fmt_o = FMT_REG;
      OPC_ALU_IMM, OPC_LOAD, OPC_JUMP_REG: fmt_o = FMT_IMM;
      OPC_STORE:                         fmt_o = FMT_STO;
      OPC_BRANCH:                        fmt_o = FMT_BRA;
      OPC_UPPER, OPC_PC_UPPER:           fmt_o = FMT_UPP;
      OPC_JUMP:                          fmt_o = FMT_JMP;
      default:                           fmt_o = FMT_NONE;
    endcase
  end

  assign illegal_o = (fmt_o == FMT_NONE);
  assign not32_o   = (opcode_i[1:0] != 2'b11);

endmodule

// File: rtl/instr_dec_imm.sv
module instr_dec_imm
  import instr_dec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:0] inst_i,
  input  fmt_e            fmt_i,
  output logic [XLEN-1:0] imm_o
);

  localparam int unsigned EXT12 = XLEN - 12;
  localparam int unsigned EXT13 = XLEN - 13;
  localparam int unsigned EXT21 = XLEN - 21;

  logic            sgn;
  logic [XLEN-1:0] imm_i_t, imm_s_t, imm_b_t, imm_j_t, imm_u_t;

  assign sgn = inst_i[31];

  assign imm_i_t = {{EXT12{sgn}}, inst_i[31:20]};
  assign imm_s_t = {{EXT12{sgn}}, inst_i[31:25], inst_i[11:7]};
  assign imm_b_t = {{EXT13{sgn}}, inst_i[31], inst_i[7], inst_i[30:25],
                    inst_i[11:8], 1'b0};
  assign imm_j_t = {{EXT21{sgn}}, inst_i[31], inst_i[19:12], inst_i[20],
                    inst_i[30:21], 1'b0};

  generate
    if (XLEN > ILEN) begin : g_wide
      assign imm_u_t = {{(XLEN-ILEN){sgn}}, inst_i[31:12], 12'h000};
    end else begin : g_native
      assign imm_u_t = {inst_i[31:12], 12'h000};
    end
  endgenerate

  always_comb begin
    unique case (fmt_i)
      FMT_IMM: imm_o = imm_i_t;
      FMT_STO: imm_o = imm_s_t;
      FMT_BRA: imm_o = imm_b_t;
      FMT_UPP: imm_o = imm_u_t;
      FMT_JMP: imm_o = imm_j_t;
      default: imm_o = '0;
    endcase
  end

endmodule

// File: rtl/instr_field_dec.sv
module instr_field_dec
  import instr_dec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]     inst_i,
  output logic [6:0]      opcode_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [2:0]      funct3_o,
  output logic [6:0]      funct7_o,
  output logic [2:0]      fmt_o,
  output logic [XLEN-1:0] imm_o,
  output logic            illegal_o,
  output logic            not32_o
);

  fields_t fld;
  fmt_e    fmt;

  instr_dec_fields u_fields (
    .inst_i   (inst_i),
    .fields_o (fld)
  );

  instr_dec_class u_class (
    .opcode_i  (fld.opcode),
    .fmt_o     (fmt),
    .illegal_o (illegal_o),
    .not32_o   (not32_o)
  );

  instr_dec_imm #(.XLEN(XLEN)) u_imm (
    .inst_i (inst_i),
    .fmt_i  (fmt),
    .imm_o  (imm_o)
  );

  assign opcode_o = fld.opcode;
  assign rd_o     = fld.rd;
  assign rs1_o    = fld.rs1;
  assign rs2_o    = fld.rs2;
  assign funct3_o = fld.funct3;
  assign funct7_o = fld.funct7;
  assign fmt_o    = fmt;

endmodule

// File: rtl/instr_field_dec_chk.sv
module instr_field_dec_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0]     inst_i,
  input logic [2:0]      fmt_o,
  input logic [XLEN-1:0] imm_o,
  input logic            illegal_o,
  input logic            not32_o
);

  logic known;
  assign known = !$isunknown(inst_i);

  always_comb begin
    if (known) begin
      assert_illegal_cls_R7: assert (illegal_o == (fmt_o == 3'd7));
      assert_short_illegal_R8: assert (!not32_o || illegal_o);
      assert_zero_imm_R9: assert (!(illegal_o || fmt_o == 3'd0) || imm_o == '0);
      assert_sign_bit_R10: assert (illegal_o || fmt_o == 3'd0
                                   || imm_o[XLEN-1] == inst_i[31]);
      assert_even_off_R4: assert (fmt_o != 3'd3 || !imm_o[0]);
      assert_even_jmp_R6: assert (fmt_o != 3'd5 || !imm_o[0]);
      assert_upper_low_R5: assert (fmt_o != 3'd4 || imm_o[11:0] == 12'h000);
    end
  end

endmodule

bind instr_field_dec instr_field_dec_chk #(.XLEN(XLEN)) u_chk (
  .inst_i    (inst_i),
  .fmt_o     (fmt_o),
  .imm_o     (imm_o),
  .illegal_o (illegal_o),
  .not32_o   (not32_o)
);

// File: tb/instr_field_dec_tb.sv
module instr_field_dec_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] inst = '0;
  logic [6:0]  opcode;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  funct3, fmt;
  logic [6:0]  funct7;
  logic [31:0] imm;
  logic        illegal, not32;

  int checks = 0;
  int errors = 0;

  instr_field_dec u_dut (
    .inst_i    (inst),
    .opcode_o  (opcode),
    .rd_o      (rd),
    .rs1_o     (rs1),
    .rs2_o     (rs2),
    .funct3_o  (funct3),
    .funct7_o  (funct7),
    .fmt_o     (fmt),
    .imm_o     (imm),
    .illegal_o (illegal),
    .not32_o   (not32)
  );

  logic [6:0] opc_list [9] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b1100111,
                               7'b0100011, 7'b1100011, 7'b0110111, 7'b0010111,
                               7'b1101111};

  function automatic int ref_fmt(logic [31:0] w);
    case (w[6:0])
      7'b0110011: return 0;
      7'b0010011, 7'b0000011, 7'b1100111: return 1;
      7'b0100011: return 2;
      7'b1100011: return 3;
      7'b0110111, 7'b0010111: return 4;
      7'b1101111: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int bitv(logic b);
    return b ? 1 : 0;
  endfunction

  // weighted sums of the scattered pieces, sign applied by subtraction
  function automatic logic [31:0] ref_imm(logic [31:0] w);
    int v;
    v = 0;
    case (ref_fmt(w))
      1: begin
        v = int'(w[31:20]);
        if (w[31]) v -= 4096;
      end
      2: begin
        v = int'(w[31:25]) * 32 + int'(w[11:7]);
        if (w[31]) v -= 4096;
      end
      3: begin
        v = bitv(w[31]) * 4096 + bitv(w[7]) * 2048 + int'(w[30:25]) * 32
            + int'(w[11:8]) * 2;
        if (w[31]) v -= 8192;
      end
      4: v = int'(w[31:12]) * 4096;
      5: begin
        v = bitv(w[31]) * 1048576 + int'(w[19:12]) * 4096
            + bitv(w[20]) * 2048 + int'(w[30:21]) * 2;
        if (w[31]) v -= 2097152;
      end
      default: v = 0;
    endcase
    return 32'(v);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s inst=%h actual=%h expected=%h", req, what, inst, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    int f;
    @(posedge clk);
    inst <= w;
    @(negedge clk);
    f = ref_fmt(w);
    chk("R1", "opcode", 32'(opcode), 32'(w[6:0]));
    chk("R1", "rd",     32'(rd),     32'(w[11:7]));
    chk("R1", "funct3", 32'(funct3), 32'(w[14:12]));
    chk("R1", "rs1",    32'(rs1),    32'(w[19:15]));
    chk("R1", "rs2",    32'(rs2),    32'(w[24:20]));
    chk("R1", "funct7", 32'(funct7), 32'(w[31:25]));
    chk("R7", "fmt",     32'(fmt),     32'(f));
    chk("R7", "illegal", 32'(illegal), (f == 7) ? 32'd1 : 32'd0);
    chk("R8", "not32",   32'(not32),   (w[1:0] != 2'b11) ? 32'd1 : 32'd0);
    case (f)
      1: chk("R2", "imm", imm, ref_imm(w));
      2: chk("R3", "imm", imm, ref_imm(w));
      3: chk("R4", "imm", imm, ref_imm(w));
      4: chk("R5", "imm", imm, ref_imm(w));
      5: chk("R6", "imm", imm, ref_imm(w));
      default: chk("R9", "imm", imm, 32'd0);
    endcase
    if (f != 0 && f != 7) chk("R10", "sign", 32'(imm[31]), 32'(w[31]));
  endtask

  task automatic expect_imm(string req, logic [31:0] w, logic [31:0] exp);
    apply(w);
    chk(req, "corner", imm, exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni <= 1'b1;
    @(negedge clk);
    // reset state: all-zero word is short and unsupported
    chk("R8", "reset not32", 32'(not32), 32'd1);
    chk("R9", "reset imm", imm, 32'd0);

    // extremes, payload all ones with sign clear and all zeros with sign set
    expect_imm("R2", 32'h7ff00013, 32'd2047);
    expect_imm("R2", 32'h80000013, 32'hfffff800);
    expect_imm("R3", 32'h7e000fa3, 32'd2047);
    expect_imm("R3", 32'h80000023, 32'hfffff800);
    expect_imm("R4", 32'h7e000fe3, 32'd4094);
    expect_imm("R4", 32'h80000063, 32'hfffff000);
    expect_imm("R5", 32'h7ffff037, 32'h7ffff000);
    expect_imm("R5", 32'h80000017, 32'h80000000);
    expect_imm("R6", 32'h7ffff06f, 32'd1048574);
    expect_imm("R6", 32'h8000006f, 32'hfff00000);

    for (int k = 0; k < 9; k++) begin
      for (int n = 0; n < 60; n++) apply({$urandom()} & 32'hffffff80 | 32'(opc_list[k]));
      // length bits broken on a supported opcode: both flags together
      for (int n = 0; n < 10; n++) begin
        logic [31:0] w;
        w = ({$urandom()} & 32'hffffff80) | 32'(opc_list[k]);
        w[n % 2] = 1'b0;
        apply(w);
        chk("R8", "short illegal", 32'(illegal), 32'd1);
      end
    end
    for (int n = 0; n < 300; n++) apply($urandom());

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule